// File: doc/BRIEF.md
# Programmable Event Counter Unit

This block is the performance monitoring unit of one memory controller channel. It holds eight 48-bit counters, each of which chooses one event from a vector of per-cycle event strobes through an 8-bit event code held in its own type register. A reserved code counts plain clock cycles. Counting is gated by a global enable and a per-counter enable, so software can freeze all counters at once or start and stop them one at a time.

Software preloads and reads back counters through a simple register port: one write strobe, a 12-bit byte address, 64-bit write data and combinational 64-bit read data. When a counter wraps it raises its own status bit. The status bits, filtered by an interrupt mask, are ORed into a single interrupt line, and software acknowledges them through a write-one-to-clear register.

Top module: `evt_cnt_unit`

## Requirements
- R1: After reset every counter reads 0, every type register reads 0, the global enable (0xEA0 bit 0) and the counter enable register (0xE70) read 0, the mask register (0x528) reads 0xFF, the status register (0x52C) reads 0 and irq_o is low.
- R2: Counter i is at address 0xE00 + 8*i; a write loads wdata[47:0] into it, and a read returns its 48-bit value zero-extended to 64 bits.
- R3: The type register of counter i is at 0xE74 + 4*i; it keeps wdata[7:0] as the event code and reads back with all higher bits zero.
- R4: An enabled counter with code 0x00 adds one on every clock edge; with a code c from 0x01 to 0x8F it adds one on each edge where evt_i[c] is high (0x83 is write data flux, 0x84 read data flux).
- R5: A counter whose code is 0x90 or above never advances, whatever evt_i carries.
- R6: While bit 0 of the control register at 0xEA0 is 0, no counter advances.
- R7: Bit i of the enable register at 0xE70 enables counter i; a counter with its bit at 0 holds its value.
- R8: When counter i steps from all ones to zero, bit i of the status register at 0x52C is set on the same edge.
- R9: irq_o is high exactly when some status bit is set whose bit in the mask register at 0x528 is 0; a mask bit of 1 suppresses that counter.
- R10: Writing a 1 to bit i of the clear register at 0x530 clears status bit i and leaves bits written 0 alone; a wrap on the same edge keeps the bit set; reads of 0x530 return 0.
- R11: A preload write to a counter on an edge where that counter would also advance loads the written value, with no increment and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 12 | Byte address for both read and write |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for reg_addr_i, combinational |
| evt_i | input | 144 | Per-cycle event strobes, bit c is event code c |
| irq_o | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
A register write on edge E shows on reg_rdata_o right after E, and its effect on counting begins on edge E+1. The global enable therefore counts on every edge from the one after its set-write up to and including its clear-write edge. Counts, overflow status and irq_o all settle on the edge that samples the strobe. The bench drives inputs half a cycle before an edge and reads just after a falling edge. The cycle-count expectations are tallied edge by edge from that rule, and the two collision cases (clear against wrap, preload against increment) are placed on the exact edge where both happen.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 64;
  localparam logic [ADDR_W-1:0] OFF_CNT_BASE  = 12'hE00;
  localparam logic [ADDR_W-1:0] OFF_TYPE_BASE = 12'hE74;
  localparam logic [ADDR_W-1:0] OFF_CTRL      = 12'hEA0;
  localparam logic [ADDR_W-1:0] OFF_EN        = 12'hE70;
  localparam logic [ADDR_W-1:0] OFF_MASK      = 12'h528;
  localparam logic [ADDR_W-1:0] OFF_STAT      = 12'h52C;
  localparam logic [ADDR_W-1:0] OFF_CLR       = 12'h530;
  localparam int unsigned CNT_STRIDE  = 8;
  localparam int unsigned TYPE_STRIDE = 4;
endpackage

// File: rtl/evt_sel.sv
module evt_sel #(
  parameter int unsigned NUM_EVT = 144,
  parameter int unsigned CODE_W  = 8
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic               hit_o
);
  localparam logic [CODE_W-1:0] CODE_LIM = CODE_W'(NUM_EVT);

  always_comb begin
    if (code_i == '0)            hit_o = 1'b1;  // cycle count
    else if (code_i < CODE_LIM)  hit_o = evt_i[code_i];
    else                         hit_o = 1'b0;
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = inc_i & ~ld_i & (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_irq.sv
module evt_irq #(
  parameter int unsigned NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] ovf_i,
  input  logic               clr_we_i,
  input  logic [NUM_CNT-1:0] clr_i,
  input  logic [NUM_CNT-1:0] mask_i,
  output logic [NUM_CNT-1:0] status_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] status_q, clr_m;

  assign clr_m = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_m) | ovf_i;  // set beats clear
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ~mask_i);
endmodule

// File: rtl/evt_cnt_unit.sv
module evt_cnt_unit
  import evt_cnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned NUM_EVT = 144,
  parameter int unsigned CODE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  logic                            ctrl_en_q;
  logic [NUM_CNT-1:0]              en_q, mask_q;
  logic [NUM_CNT-1:0][CODE_W-1:0]  type_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_w;
  logic [NUM_CNT-1:0]              ovf_w, hit_w, inc_w, ld_w, type_we;
  logic [NUM_CNT-1:0]              status_w;
  logic                            ctrl_we, en_we, mask_we, clr_we;
  logic                            unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:CNT_W];

  assign ctrl_we = reg_we_i && (reg_addr_i == OFF_CTRL);
  assign en_we   = reg_we_i && (reg_addr_i == OFF_EN);
  assign mask_we = reg_we_i && (reg_addr_i == OFF_MASK);
  assign clr_we  = reg_we_i && (reg_addr_i == OFF_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      en_q      <= '0;
      mask_q    <= '1;
    end else begin
      if (ctrl_we) ctrl_en_q <= reg_wdata_i[0];
      if (en_we)   en_q      <= reg_wdata_i[NUM_CNT-1:0];
      if (mask_we) mask_q    <= reg_wdata_i[NUM_CNT-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] A_CNT  = OFF_CNT_BASE  + ADDR_W'(CNT_STRIDE * i);
    localparam logic [ADDR_W-1:0] A_TYPE = OFF_TYPE_BASE + ADDR_W'(TYPE_STRIDE * i);

    assign ld_w[i]    = reg_we_i && (reg_addr_i == A_CNT);
    assign type_we[i] = reg_we_i && (reg_addr_i == A_TYPE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         type_q[i] <= '0;
      else if (type_we[i]) type_q[i] <= reg_wdata_i[CODE_W-1:0];
    end

    evt_sel #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) i_sel (
      .evt_i  (evt_i),
      .code_i (type_q[i]),
      .hit_o  (hit_w[i])
    );

    assign inc_w[i] = ctrl_en_q & en_q[i] & hit_w[i];

    evt_counter #(.CNT_W(CNT_W)) i_counter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc_w[i]),
      .ld_i     (ld_w[i]),
      .ld_val_i (reg_wdata_i[CNT_W-1:0]),
      .cnt_o    (cnt_w[i]),
      .ovf_o    (ovf_w[i])
    );
  end

  evt_irq #(.NUM_CNT(NUM_CNT)) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ovf_i    (ovf_w),
    .clr_we_i (clr_we),
    .clr_i    (reg_wdata_i[NUM_CNT-1:0]),
    .mask_i   (mask_q),
    .status_o (status_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr_i == OFF_CNT_BASE + ADDR_W'(CNT_STRIDE * i))
        reg_rdata_o = DATA_W'(cnt_w[i]);
      if (reg_addr_i == OFF_TYPE_BASE + ADDR_W'(TYPE_STRIDE * i))
        reg_rdata_o = DATA_W'(type_q[i]);
    end
    case (reg_addr_i)
      OFF_CTRL: reg_rdata_o = DATA_W'(ctrl_en_q);
      OFF_EN:   reg_rdata_o = DATA_W'(en_q);
      OFF_MASK: reg_rdata_o = DATA_W'(mask_q);
      OFF_STAT: reg_rdata_o = DATA_W'(status_w);
      default:  ;
    endcase
  end
endmodule

// File: rtl/evt_cnt_chk.sv
module evt_cnt_chk
  import evt_cnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 48
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          reg_we_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [DATA_W-1:0]             reg_rdata_o,
  input logic                          irq_o,
  input logic                          ctrl_en,
  input logic [NUM_CNT-1:0]            cnt_en,
  input logic [NUM_CNT-1:0]            mask,
  input logic [NUM_CNT-1:0]            status,
  input logic [NUM_CNT-1:0]            ovf,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
  AST_GLOBAL_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en && !reg_we_i) |=> $stable(cnt)); // R6
  AST_ALL_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_en == '0) && !reg_we_i) |=> $stable(cnt)); // R7
  AST_WRAP_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf) |=> ((status & $past(ovf)) == $past(ovf))); // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status)); // R9
  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |-> !irq_o); // R9
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFF_CLR) |-> (reg_rdata_o == '0)); // R10
endmodule

bind evt_cnt_unit evt_cnt_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) i_evt_cnt_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .ctrl_en     (ctrl_en_q),
  .cnt_en      (en_q),
  .mask        (mask_q),
  .status      (status_w),
  .ovf         (ovf_w),
  .cnt         (cnt_w)
);

// File: tb/test_evt_cnt_unit.sv
module test_evt_cnt_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [11:0]  addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic [143:0] evt = '0;
  logic         irq;
  int n_cmp = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  evt_cnt_unit i_evt_cnt_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  localparam logic [11:0] A_CTRL = 12'hEA0, A_EN = 12'hE70, A_MASK = 12'h528,
                          A_STAT = 12'h52C, A_CLR = 12'h530;

  function automatic logic [11:0] a_cnt(int i);  return 12'hE00 + 12'(8 * i); endfunction
  function automatic logic [11:0] a_type(int i); return 12'hE74 + 12'(4 * i); endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; evt = '0;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [63:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic irq_chk(string tag, logic exp);
    @(negedge clk);
    #1 chk(tag, {63'b0, irq}, {63'b0, exp});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) begin
      rd_chk("R1 counter", a_cnt(i), 64'h0);
      rd_chk("R1 type", a_type(i), 64'h0);
    end
    rd_chk("R1 ctrl", A_CTRL, 64'h0);
    rd_chk("R1 enable", A_EN, 64'h0);
    rd_chk("R1 mask", A_MASK, 64'hFF);
    rd_chk("R1 status", A_STAT, 64'h0);
    irq_chk("R1 irq", 1'b0);
  endtask

  task automatic t_access;
    wr(a_cnt(3), 64'hFFFF_1234_5678_9ABC);
    rd_chk("R2 preload 48b", a_cnt(3), 64'h0000_1234_5678_9ABC);
    wr(a_cnt(2), 64'h0000_0000_0000_0042);
    rd_chk("R2 preload other", a_cnt(2), 64'h42);
    rd_chk("R2 neighbour kept", a_cnt(3), 64'h0000_1234_5678_9ABC);
    wr(a_type(1), 64'hFFFF_FFFF_FFFF_FF83);
    rd_chk("R3 type field", a_type(1), 64'h83);
  endtask

  task automatic t_count;
    int e83 = 0, e84 = 0, e8f = 0;
    for (int i = 0; i < 6; i++) wr(a_cnt(i), 64'h0);
    wr(a_cnt(5), 64'd7);
    wr(a_type(0), 64'h00);
    wr(a_type(1), 64'h83);
    wr(a_type(2), 64'h84);
    wr(a_type(3), 64'h95);
    wr(a_type(4), 64'h8F);
    wr(a_type(5), 64'h00);
    wr(A_EN, 64'h1F);
    wr(A_CTRL, 64'h1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      evt = '1;
      evt[8'h83] = (i % 2 == 0);
      evt[8'h84] = (i % 3 == 0);
      evt[8'h8F] = (i < 5);
      if (evt[8'h83]) e83++;
      if (evt[8'h84]) e84++;
      if (evt[8'h8F]) e8f++;
    end
    wr(A_CTRL, 64'h0);
    rd_chk("R4 cycles", a_cnt(0), 64'(21));
    rd_chk("R4 write flux", a_cnt(1), 64'(e83));
    rd_chk("R4 read flux", a_cnt(2), 64'(e84));
    rd_chk("R5 unknown code", a_cnt(3), 64'h0);
    rd_chk("R4 top code", a_cnt(4), 64'(e8f));
    rd_chk("R7 disabled", a_cnt(5), 64'd7);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      evt = '1;
    end
    rd_chk("R6 global off cycles", a_cnt(0), 64'(21));
    rd_chk("R6 global off flux", a_cnt(1), 64'(e83));
    @(negedge clk) evt = '0;
  endtask

  task automatic t_overflow;
    wr(A_EN, 64'h40);
    wr(A_MASK, 64'hBF);
    wr(a_cnt(6), 64'h0000_FFFF_FFFF_FFFE);
    irq_chk("R9 idle", 1'b0);
    wr(A_CTRL, 64'h1);
    @(negedge clk);
    @(negedge clk);
    wr(A_CTRL, 64'h0);
    rd_chk("R8 wrapped", a_cnt(6), 64'h1);
    rd_chk("R8 status", A_STAT, 64'h40);
    irq_chk("R9 unmasked", 1'b1);
    wr(A_MASK, 64'hFF);
    irq_chk("R9 masked", 1'b0);
    rd_chk("R9 status kept", A_STAT, 64'h40);
    wr(A_MASK, 64'h00);
    irq_chk("R9 unmask again", 1'b1);
    wr(A_CLR, 64'h00);
    rd_chk("R10 zero write", A_STAT, 64'h40);
    wr(A_CLR, 64'h40);
    rd_chk("R10 cleared", A_STAT, 64'h0);
    irq_chk("R10 irq low", 1'b0);
    rd_chk("R10 clear reads 0", A_CLR, 64'h0);
  endtask

  task automatic t_collide;
    wr(A_EN, 64'h80);
    wr(a_cnt(7), 64'h0000_FFFF_FFFF_FFFF);
    wr(A_CTRL, 64'h1);
    wr(A_CLR, 64'h80);
    wr(A_CTRL, 64'h0);
    rd_chk("R10 set beats clear", A_STAT, 64'h80);
    irq_chk("R10 irq stays", 1'b1);
    wr(A_CLR, 64'hFF);
    rd_chk("R10 final clear", A_STAT, 64'h0);
    wr(A_EN, 64'h01);
    wr(A_CTRL, 64'h1);
    wr(a_cnt(0), 64'd100);
    wr(A_CTRL, 64'h0);
    rd_chk("R11 preload wins", a_cnt(0), 64'd101);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_access();
    t_count();
    t_overflow();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule